// File: doc/BRIEF.md
# FIFO Command Status Sequencer

This block is the register-side sequencer of a byte-wide host interface to a security module. A host reads and writes single bytes at byte offsets. Through these accesses it loads a command into a data port, starts it, and drains the response from the same port. The block holds four things: the status byte, the extended status byte, a 16-bit burst count, and the data port, which is reachable at two aliased offsets. It steps each command through five phases: ready, byte intake, execution, response available, and response drain.

The command engine is a stub. It echoes the command back as the response after a latency, in cycles, that is set on the `lat_i` input. If the host cancels during execution, the stored response is replaced by a fixed 10-byte cancelled header. A sticky flag records data writes that arrive while the block does not expect bytes. The register read path is combinational. A read of the data port advances the response pointer on the clock edge of that access.

Top module: `fifo_cmd_seq`

## Requirements
- R1: After reset, status (offset 0x18) reads 0xC8, burst count (0x19 low byte, 0x1A high byte) reads DEPTH, `ovf_o` is 0, and a data-port read returns 0xFF. Status bit 7 is valid, bit 6 is ready, bit 4 is data-available and bit 3 is expect.
- R2: In the ready and intake phases, a write to 0x24 or to 0x80 appends one command byte. Command bytes 2 to 5 give the declared length, most significant byte first, clamped to DEPTH. Expect stays 1 while fewer than 6 bytes have arrived, or fewer than the clamped length.
- R3: While expect is 1, the burst count equals DEPTH minus the received count when fewer than 6 bytes are in, and otherwise the clamped length minus the received count. While expect is 0, the burst count is 0.
- R4: A data write made while expect is 0 is dropped and sets `ovf_o`. `ovf_o` stays set until a ready write or a reset clears it.
- R5: Writing 1 to status bit 5 starts execution only when bytes have been received and expect is 0. Otherwise the write has no effect.
- R6: From a go write until execution ends, status reads 0x00. Without a cancel, execution lasts `lat_i`+1 cycles.
- R7: After execution, status bit 4 is 1 until every response byte has been read. Data-port reads return the command bytes in order. A read with no data left returns 0xFF and moves nothing, and status then reads 0x80.
- R8: Writing 1 to status bit 1 while the response is available restarts the response at byte 0. In any other phase the write has no effect.
- R9: Writing 1 to extended-status (0x1B) bit 0 during execution ends execution at once. The response then becomes the 10 bytes 80 01 00 00 00 0A 00 00 09 09.
- R10: The same cancel write made outside execution has no effect on status or on the response.
- R11: Writing 1 to status bit 6 in the response phase or the intake phase discards the command and the response and returns to the ready phase (status 0xC8).
- R12: The extended status byte reads FAMILY in bits 3:2 and 0 in all other bits. The default FAMILY is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| lat_i | input | LAT_W | Execution latency of the engine stub, in cycles |
| ovf_o | output | 1 | Sticky dropped-write flag |

## Verification
A wrong received count or a wrong captured length first shows in the burst count, which is read before every data write. It shows next in the expect bit, at the very byte where intake should stop. A phase error shows within one access as a wrong status byte. For example, a go that is taken too early makes status read 0x00 instead of 0xC8, and a cancel taken outside execution changes the response bytes. A slip in the response pointer shows on the next data-port read, or on the first read after a retry.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {ST_READY, ST_RECV, ST_EXEC, ST_DONE} seq_st_e;

  localparam logic [11:0] OFS_STS   = 12'h018;
  localparam logic [11:0] OFS_BC_LO = 12'h019;
  localparam logic [11:0] OFS_BC_HI = 12'h01A;
  localparam logic [11:0] OFS_STX   = 12'h01B;
  localparam logic [11:0] OFS_FIFO  = 12'h024;
  localparam logic [11:0] OFS_XFIFO = 12'h080;

  localparam int HDR_LEN  = 6;
  localparam int CANC_LEN = 10;

  function automatic logic [7:0] cancel_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    cancel_byte = 8'h80;
      4'd1:    cancel_byte = 8'h01;
      4'd5:    cancel_byte = 8'h0A;
      4'd8:    cancel_byte = 8'h09;
      4'd9:    cancel_byte = 8'h09;
      default: cancel_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/fcs_buf.sv
module fcs_buf #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [7:0]    wr_byte_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_byte_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_byte_i;
  end

  assign rd_byte_o = mem_q[rd_idx_i];
endmodule

// File: rtl/fcs_exec.sv
module fcs_exec #(
  parameter int LAT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [LAT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= lat_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0) && !abort_i;

  // R6
  stub_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0 && !abort_i) |=> busy_q);
endmodule

// File: rtl/fifo_cmd_seq.sv
module fifo_cmd_seq
  import fcs_pkg::*;
#(
  parameter int         DEPTH  = 32,
  parameter int         LAT_W  = 16,
  parameter int         ADDR_W = 12,
  parameter logic [1:0] FAMILY = 2'b01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [LAT_W-1:0]  lat_i,
  output logic              ovf_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  seq_st_e      st_q;
  logic [CW-1:0] cnt_q, rd_ptr_q, rsp_len_q, len_eff;
  logic [31:0]  len_q;
  logic         canc_q, ovf_q;

  logic [11:0] adr;
  logic wr, rd, is_fifo, sts_wr, stx_wr, go_wr, ready_wr, retry_wr, cancel_wr;
  logic data_wr, accept, drop, expect_b, avail, pop, start, abort, ex_done, ex_busy;
  logic [15:0] burst;
  logic [7:0]  buf_byte, rsp_byte;

  assign adr       = 12'(addr_i);
  assign wr        = req_i && we_i;
  assign rd        = req_i && !we_i;
  assign is_fifo   = (adr == OFS_FIFO) || (adr == OFS_XFIFO);
  assign sts_wr    = wr && (adr == OFS_STS);
  assign stx_wr    = wr && (adr == OFS_STX);
  assign go_wr     = sts_wr && wdata_i[5];
  assign ready_wr  = sts_wr && wdata_i[6];
  assign retry_wr  = sts_wr && wdata_i[1];
  assign cancel_wr = stx_wr && wdata_i[0];

  assign len_eff  = (len_q > 32'(DEPTH)) ? CW'(DEPTH) : len_q[CW-1:0];
  assign expect_b = (st_q == ST_READY) ||
                    ((st_q == ST_RECV) && ((cnt_q < CW'(HDR_LEN)) || (cnt_q < len_eff)));
  assign data_wr  = wr && is_fifo;
  assign accept   = data_wr && expect_b;
  assign drop     = data_wr && !expect_b;
  assign avail    = (st_q == ST_DONE) && (rd_ptr_q < rsp_len_q);
  assign pop      = rd && is_fifo && avail;
  assign start    = (st_q == ST_RECV) && go_wr && !ready_wr && !expect_b;
  assign abort    = (st_q == ST_EXEC) && cancel_wr;

  always_comb begin
    if (!expect_b)                  burst = '0;
    else if (cnt_q < CW'(HDR_LEN))  burst = 16'(DEPTH) - 16'(cnt_q);
    else                            burst = 16'(len_eff) - 16'(cnt_q);
  end

  fcs_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i    (clk_i),
    .wr_en_i  (accept),
    .wr_idx_i (cnt_q[IW-1:0]),
    .wr_byte_i(wdata_i),
    .rd_idx_i (rd_ptr_q[IW-1:0]),
    .rd_byte_o(buf_byte)
  );

  fcs_exec #(.LAT_W(LAT_W)) u_exec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .abort_i(abort),
    .lat_i  (lat_i),
    .busy_o (ex_busy),
    .done_o (ex_done)
  );

  assign rsp_byte = canc_q ? cancel_byte(rd_ptr_q[3:0]) : buf_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_READY;
      cnt_q     <= '0;
      len_q     <= '0;
      rd_ptr_q  <= '0;
      rsp_len_q <= '0;
      canc_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (drop) ovf_q <= 1'b1;
      unique case (st_q)
        ST_READY: begin
          if (ready_wr) ovf_q <= 1'b0;
          if (accept) begin
            st_q  <= ST_RECV;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RECV: begin
          if (ready_wr) begin
            st_q  <= ST_READY;
            cnt_q <= '0;
            len_q <= '0;
            ovf_q <= 1'b0;
          end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q >= CW'(2) && cnt_q < CW'(HDR_LEN)) len_q <= {len_q[23:0], wdata_i};
          end else if (start) begin
            st_q      <= ST_EXEC;
            rsp_len_q <= cnt_q;
            canc_q    <= 1'b0;
          end
        end
        ST_EXEC: begin
          if (abort) begin
            st_q      <= ST_DONE;
            canc_q    <= 1'b1;
            rsp_len_q <= CW'(CANC_LEN);
            rd_ptr_q  <= '0;
          end else if (ex_done) begin
            st_q     <= ST_DONE;
            rd_ptr_q <= '0;
          end
        end
        ST_DONE: begin
          if (ready_wr) begin
            st_q     <= ST_READY;
            cnt_q    <= '0;
            len_q    <= '0;
            rd_ptr_q <= '0;
            canc_q   <= 1'b0;
            ovf_q    <= 1'b0;
          end else if (retry_wr) begin
            rd_ptr_q <= '0;
          end else if (pop) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
          end
        end
        default: st_q <= ST_READY;
      endcase
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (adr == OFS_STS)
      rdata_o = {st_q != ST_EXEC, (st_q == ST_READY) || (st_q == ST_RECV), 1'b0,
                 avail, expect_b, 3'b000};
    else if (adr == OFS_BC_LO) rdata_o = burst[7:0];
    else if (adr == OFS_BC_HI) rdata_o = burst[15:8];
    else if (adr == OFS_STX)   rdata_o = {4'b0000, FAMILY, 2'b00};
    else if (is_fifo)          rdata_o = avail ? rsp_byte : 8'hFF;
  end

  assign ovf_o = ovf_q;

  // R10
  cancel_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_wr && st_q != ST_EXEC) |=> ($stable(st_q) && $stable(canc_q) && $stable(rsp_len_q)));
  // R6
  exec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EXEC && !ex_done && !cancel_wr) |=> (st_q == ST_EXEC));
  // R8
  retry_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_wr && !ready_wr && st_q == ST_DONE) |=> (rd_ptr_q == '0));
  // R4
  drop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> ovf_q);
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R6
  exec_engine_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EXEC) |-> ex_busy);
endmodule

// File: tb/sim_fifo_cmd_seq.sv
module sim_fifo_cmd_seq;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] lat = '0;
  logic        ovf;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] cmd [64];

  always #2 clk = ~clk;

  fifo_cmd_seq #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .lat_i(lat), .ovf_o(ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #0.5 req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #0.5 req = 1'b0; we = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [11:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  function automatic int eff_len(input int declared);
    return (declared > DEPTH) ? DEPTH : declared;
  endfunction

  function automatic int cap_len(input int declared);
    return (eff_len(declared) < 6) ? 6 : eff_len(declared);
  endfunction

  function automatic int exp_burst(input int cnt, input int declared);
    if (cnt < 6) return DEPTH - cnt;
    if (cnt < eff_len(declared)) return eff_len(declared) - cnt;
    return 0;
  endfunction

  function automatic logic [7:0] canc_exp(input int i);
    logic [7:0] t [10] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h09, 8'h09};
    return t[i];
  endfunction

  task automatic send_cmd(input int declared, input int nbytes, input bit chk_bc);
    logic [7:0] lo, hi, b;
    for (int i = 0; i < nbytes; i++) begin
      if (chk_bc) begin
        rd(12'h019, lo); rd(12'h01A, hi);
        check("R3 burst", {hi, lo}, exp_burst(i, declared));
      end
      case (i)
        2: b = 8'(declared >> 24);
        3: b = 8'(declared >> 16);
        4: b = 8'(declared >> 8);
        5: b = 8'(declared);
        default: b = 8'($urandom);
      endcase
      if (i < 64) cmd[i] = b;
      wr(($urandom % 2) ? 12'h024 : 12'h080, b);
    end
  endtask

  task automatic wait_exec(input int l, input bit chk_len);
    logic [7:0] d;
    int polls = 0;
    rd(12'h018, d);
    while (d[7] == 1'b0 && polls < 1000) begin
      polls++;
      check("R6 exec status", d, 8'h00);
      rd(12'h018, d);
    end
    if (chk_len) check("R6 exec length", polls, l + 1);
  endtask

  task automatic drain(input int n, input bit canc, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rd(12'h018, d);
      check({tag, " data bit"}, d, 8'h90);
      rd(12'h024, d);
      check({tag, " byte"}, d, canc ? canc_exp(i) : cmd[i]);
    end
    chk_rd("R7 drained status", 12'h018, 8'h80);
    chk_rd("R7 empty read", 12'h080, 8'hFF);
  endtask

  initial begin
    #(4 * 180000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed = 17;
    int declared, cap, k;
    bit canc;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;

    // R1 reset state, R12 extended status
    chk_rd("R1 status", 12'h018, 8'hC8);
    chk_rd("R1 burst lo", 12'h019, DEPTH);
    chk_rd("R1 burst hi", 12'h01A, 0);
    check("R1 ovf", ovf, 0);
    chk_rd("R1 fifo", 12'h024, 8'hFF);
    chk_rd("R12 family", 12'h01B, 8'h04);

    // R5, R8, R10 ignored in intake; R11 discard
    send_cmd(20, 8, 1);
    wr(12'h018, 8'h20);
    chk_rd("R5 go ignored", 12'h018, 8'hC8);
    wr(12'h018, 8'h02);
    chk_rd("R8 retry ignored", 12'h018, 8'hC8);
    wr(12'h01B, 8'h01);
    chk_rd("R10 cancel ignored", 12'h018, 8'hC8);
    chk_rd("R3 partial burst", 12'h019, 12);
    wr(12'h018, 8'h40);
    chk_rd("R11 discard status", 12'h018, 8'hC8);
    chk_rd("R11 discard burst", 12'h019, DEPTH);

    // R4 overflow, R10 cancel after data-available
    lat = 16'd4;
    send_cmd(8, 8, 1);
    chk_rd("R2 loaded status", 12'h018, 8'hC0);
    wr(12'h024, 8'hEE);
    check("R4 ovf set", ovf, 1);
    wr(12'h018, 8'h20);
    wait_exec(4, 1);
    wr(12'h01B, 8'h01);
    chk_rd("R10 cancel after data", 12'h018, 8'h90);
    wr(12'h024, 8'h55);
    drain(8, 0, "R7 echo");
    check("R4 ovf sticky", ovf, 1);
    wr(12'h018, 8'h40);
    check("R4 ovf cleared", ovf, 0);
    chk_rd("R11 back to ready", 12'h018, 8'hC8);

    // R2 clamp to DEPTH and short length
    lat = 16'd0;
    send_cmd(100, DEPTH, 1);
    chk_rd("R2 clamp expect", 12'h018, 8'hC0);
    wr(12'h018, 8'h20);
    wait_exec(0, 1);
    drain(DEPTH, 0, "R7 clamp");
    wr(12'h018, 8'h40);
    send_cmd(2, 6, 1);
    chk_rd("R2 short expect", 12'h018, 8'hC0);
    wr(12'h018, 8'h20);
    wait_exec(0, 1);
    drain(6, 0, "R7 short");
    wr(12'h018, 8'h40);

    // random commands
    for (int it = 0; it < 40; it++) begin
      declared = ($urandom % 5 == 0) ? DEPTH + 1 + ($urandom % 40) : 6 + ($urandom % (DEPTH - 5));
      cap = cap_len(declared);
      lat = 16'(3 + ($urandom % 12));
      canc = ($urandom % 4 == 0);
      send_cmd(declared, cap, 1);
      chk_rd("R2 intake done", 12'h018, 8'hC0);
      wr(12'h018, 8'h20);
      if (canc) begin
        wr(12'h01B, 8'h01);
        chk_rd("R9 cancel status", 12'h018, 8'h90);
        k = $urandom % 10;
        for (int i = 0; i < k; i++) chk_rd("R9 cancel byte", 12'h024, canc_exp(i));
        wr(12'h018, 8'h02);
        drain(10, 1, "R9 cancel");
      end else begin
        wait_exec(int'(lat), 1);
        k = $urandom % cap;
        for (int i = 0; i < k; i++) chk_rd("R7 partial byte", 12'h080, cmd[i]);
        wr(12'h018, 8'h02);
        drain(cap, 0, "R8 retry");
      end
      wr(12'h018, 8'h40);
      chk_rd("R11 ready", 12'h018, 8'hC8);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule